// File: doc/BRIEF.md
# Slow-Idle Clock Controller

This block parks a processor core in a low-power wait state when the core issues an idle request, and releases it when an enabled interrupt shows up. The request may carry a clock divisor. Without one, the core clock enable is held low and the core wakes within a single cycle of an unmasked interrupt. With a divisor, the core is not frozen but slowed. The core clock enable and the serial-clock, clock-output and timer tick enables all pulse once every n base cycles, where n is 16, 32, 64 or 128.

Wake-up from the divided form is aligned to the next divided tick. An interrupt seen between ticks is remembered, so the core leaves idle at that tick even if the request has already gone away. DMA cycle-steal requests are granted in every state, one requester per cycle, so that background transfers continue while the core sleeps. The core resumes at the instruction after the idle request. That sequencing is the decoder's job. This block signals it with a one-cycle resume pulse.

Top module: `slow_idle_ctrl`

## Requirements
- R1: While reset is asserted and on the cycle after it, all four clock enables are high, resume is low, the DMA grant is zero and the free-running 7-bit tick counter is 0. The counter then advances by one per cycle and wraps at 128.
- R2: An idle request with `div_present` low, taken while running, makes `core_ce` low from the next cycle on. The three peripheral enables stay high.
- R3: In plain idle, an unmasked pending interrupt seen on a clock edge gives `resume` high and `core_ce` high in the cycle right after that edge.
- R4: An interrupt line whose `irq_mask` bit is 0 never wakes the block, in either idle form. A mask bit of 1 enables the line.
- R5: `div_code` selects n = 16 (00), 32 (01), 64 (10) or 128 (11). In divided idle, `core_ce`, `sclk_ce`, `clkout_ce` and `timer_ce` are high exactly in the cycles where the low log2(n) bits of the tick counter are zero.
- R6: In divided idle, an unmasked interrupt is latched and the block resumes on the first edge at which the counter's low log2(n) bits are zero, at most n cycles after the interrupt is seen. The interrupt does not need to stay asserted.
- R7: `resume` is high for exactly one cycle, and only when the block leaves an idle state. The block is then running with every enable high.
- R8: In every state, `dma_gnt` is one-hot on the lowest-index bit of `dma_req` sampled at the previous edge, and is zero if there was no request.
- R9: An idle request issued while an unmasked interrupt is already pending resumes at the next eligible point: one cycle later in plain idle, or the next tick in divided idle.
- R10: Idle requests arriving while already idle are ignored. The divisor stays the one latched at entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Idle request pulse from the decoder |
| div_present | input | 1 | The request carries a divisor |
| div_code | input | 2 | Divisor select: 00=16, 01=32, 10=64, 11=128 |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_mask | input | NIRQ | Per-line enable, 1 = enabled |
| dma_req | input | NDMA | DMA / autobuffer cycle-steal requests |
| core_ce | output | 1 | Core clock enable |
| sclk_ce | output | 1 | Serial-clock enable |
| clkout_ce | output | 1 | Clock-output enable |
| timer_ce | output | 1 | Timer tick enable |
| resume | output | 1 | One-cycle wake pulse |
| dma_gnt | output | NDMA | One-hot DMA grant |

## Verification
The hardest case to reach is a short interrupt pulse that arrives between two divided ticks. The pulse must be remembered, and the block must still resume at the tick, for all four ratios. The stimulus enters each divided idle at a different counter phase, raises an unmasked line for a single cycle, drops it, and waits for resume. The cycle-accurate bench model predicts the exact tick, and the bench also bounds the latency by n. Further cases mix masked pulses, DMA traffic and repeated idle requests during the wait, and issue idle requests while an interrupt is already pending.

// File: rtl/slow_idle_pkg.sv
package slow_idle_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_SLOW = 2'd2
  } sidle_state_t;
endpackage

// File: rtl/sidle_tick_counter.sv
module sidle_tick_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  assign cnt_d = rst ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  a_r1_counter_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/sidle_dma_grant.sv
module sidle_dma_grant #(
  parameter int NDMA = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDMA-1:0] dma_req,
  output logic [NDMA-1:0] dma_gnt
);
  logic [NDMA-1:0] pick;

  assign pick = dma_req & (~dma_req + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) dma_gnt <= '0;
    else     dma_gnt <= pick;
  end

  a_r8_one_grant: assert property (@(posedge clk) disable iff (rst)
    (|dma_req) |=> ($countones(dma_gnt) == 1));
  a_r8_no_grant: assert property (@(posedge clk) disable iff (rst)
    !(|dma_req) |=> (dma_gnt == '0));
endmodule

// File: rtl/sidle_wake_ctrl.sv
module sidle_wake_ctrl
  import slow_idle_pkg::*;
#(
  parameter int NIRQ      = 4,
  parameter int CNT_W     = 7,
  parameter int BASE_LOG2 = 4,
  parameter int CODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              div_present,
  input  logic [CODE_W-1:0] div_code,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NIRQ-1:0]   irq_mask,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic              core_ce,
  output logic              sclk_ce,
  output logic              clkout_ce,
  output logic              timer_ce,
  output logic              resume
);
  sidle_state_t      state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              armed_q, armed_d;
  logic              resume_d;
  logic              pend;
  logic              tick_now, tick_next;

  function automatic logic tick_of(input logic [CNT_W-1:0] c,
                                   input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] m;
    m = ~({CNT_W{1'b1}} << (BASE_LOG2 + int'(code)));
    return (c & m) == '0;
  endfunction

  assign pend      = |(irq_req & irq_mask);
  assign tick_now  = tick_of(cnt_q, code_q);
  assign tick_next = tick_of(cnt_d, code_d);

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    armed_d  = armed_q;
    resume_d = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (idle_req) begin
          armed_d = 1'b0;
          if (div_present) begin
            state_d = ST_SLOW;
            code_d  = div_code;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (pend) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
        end
      end
      ST_SLOW: begin
        if ((pend || armed_q) && tick_now) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
          armed_d  = 1'b0;
        end else if (pend) begin
          armed_d = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
    if (rst) begin
      state_d  = ST_RUN;
      code_d   = '0;
      armed_d  = 1'b0;
      resume_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    state_q   <= state_d;
    code_q    <= code_d;
    armed_q   <= armed_d;
    resume    <= resume_d;
    core_ce   <= (state_d == ST_RUN) || ((state_d == ST_SLOW) && tick_next);
    sclk_ce   <= (state_d != ST_SLOW) || tick_next;
    clkout_ce <= (state_d != ST_SLOW) || tick_next;
    timer_ce  <= (state_d != ST_SLOW) || tick_next;
  end

  a_r7_resume_single: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);
  a_r2_plain_gates_core: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && idle_req && !div_present) |=> (!core_ce && sclk_ce));
  a_r4_masked_no_wake: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN && !pend && !armed_q) |=> !resume);
  a_r3_plain_wake: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && pend) |=> (resume && core_ce));
  a_r6_slow_wake_on_tick: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLOW && !tick_now) |=> !resume);
endmodule

// File: rtl/slow_idle_ctrl.sv
module slow_idle_ctrl #(
  parameter int NIRQ      = 4,
  parameter int NDMA      = 3,
  parameter int BASE_LOG2 = 4,
  parameter int CODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              div_present,
  input  logic [CODE_W-1:0] div_code,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NIRQ-1:0]   irq_mask,
  input  logic [NDMA-1:0]   dma_req,
  output logic              core_ce,
  output logic              sclk_ce,
  output logic              clkout_ce,
  output logic              timer_ce,
  output logic              resume,
  output logic [NDMA-1:0]   dma_gnt
);
  localparam int CNT_W = BASE_LOG2 + (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  sidle_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  sidle_wake_ctrl #(
    .NIRQ(NIRQ), .CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)
  ) u_wake (
    .clk(clk), .rst(rst), .idle_req(idle_req), .div_present(div_present),
    .div_code(div_code), .irq_req(irq_req), .irq_mask(irq_mask),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .core_ce(core_ce), .sclk_ce(sclk_ce),
    .clkout_ce(clkout_ce), .timer_ce(timer_ce), .resume(resume)
  );

  sidle_dma_grant #(.NDMA(NDMA)) u_dma (
    .clk(clk), .rst(rst), .dma_req(dma_req), .dma_gnt(dma_gnt)
  );
endmodule

// File: tb/tb_slow_idle_ctrl.sv
module tb_slow_idle_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idle_req = 1'b0, div_present = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic [3:0] irq_req = '0, irq_mask = '0;
  logic [2:0] dma_req = '0;
  logic       core_ce, sclk_ce, clkout_ce, timer_ce, resume;
  logic [2:0] dma_gnt;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  int mstate = 0, mcnt = 0, mcode = 0;
  bit marmed = 0, mresume = 0;
  int mgnt = 0;

  always #2.5 clk = ~clk;

  slow_idle_ctrl dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .div_present(div_present),
    .div_code(div_code), .irq_req(irq_req), .irq_mask(irq_mask),
    .dma_req(dma_req), .core_ce(core_ce), .sclk_ce(sclk_ce),
    .clkout_ce(clkout_ce), .timer_ce(timer_ce), .resume(resume),
    .dma_gnt(dma_gnt)
  );

  function automatic bit m_tick(int c, int code);
    return (c % (16 << code)) == 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit pend, tk, nres;
    int r;
    @(posedge clk);
    if (rst) begin
      mstate = 0; mcnt = 0; mcode = 0; marmed = 0; mresume = 0; mgnt = 0;
    end else begin
      pend = |(irq_req & irq_mask);
      tk = m_tick(mcnt, mcode);
      nres = 0;
      case (mstate)
        0: if (idle_req) begin
             marmed = 0;
             if (div_present) begin mstate = 2; mcode = div_code; end
             else mstate = 1;
           end
        1: if (pend) begin mstate = 0; nres = 1; end
        2: if ((pend || marmed) && tk) begin mstate = 0; nres = 1; marmed = 0; end
           else if (pend) marmed = 1;
        default: ;
      endcase
      mcnt = (mcnt + 1) % 128;
      mresume = nres;
      r = dma_req;
      mgnt = r & (-r) & 7;
    end
    #1;
    tk = m_tick(mcnt, mcode);
    check(cur_req, core_ce, (mstate == 0) ? 1 : (mstate == 1) ? 0 : tk, "core_ce");
    check(cur_req, sclk_ce, (mstate == 2) ? tk : 1, "sclk_ce");
    check(cur_req, clkout_ce, (mstate == 2) ? tk : 1, "clkout_ce");
    check(cur_req, timer_ce, (mstate == 2) ? tk : 1, "timer_ce");
    check(cur_req, resume, mresume, "resume");
    check("R8", dma_gnt, mgnt, "dma_gnt");
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_resume(int limit, output int lat);
    lat = 0;
    while (!resume && lat < limit) begin step(); lat++; end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    cur_req = "R1";
    cycles(3);
    rst = 1'b0;
    step();
    check("R1", {core_ce, sclk_ce, clkout_ce, timer_ce}, 15, "enables after reset");
    check("R1", resume, 0, "resume after reset");

    cur_req = "R8";
    dma_req = 3'b110; step();
    dma_req = 3'b101; step();
    dma_req = 3'b000; step();

    cur_req = "R2";
    idle_req = 1; div_present = 0; step();
    idle_req = 0;
    check("R2", core_ce, 0, "core gated in plain idle");
    cycles(5);
    cur_req = "R4";
    irq_mask = 4'b0011; irq_req = 4'b0100; dma_req = 3'b100; cycles(10);
    check("R4", resume, 0, "masked line in plain idle");
    cur_req = "R10";
    idle_req = 1; div_present = 1; div_code = 2'b00; step();
    idle_req = 0; div_present = 0; cycles(20);
    check("R10", core_ce, 0, "repeat request ignored");
    cur_req = "R3";
    irq_req = 4'b0001; step();
    check("R3", resume, 1, "plain wake pulse");
    check("R3", core_ce, 1, "core running after wake");
    irq_req = 0; dma_req = 0;
    cur_req = "R7";
    step();
    check("R7", resume, 0, "resume single cycle");

    for (int c = 0; c < 4; c++) begin
      cur_req = "R5";
      cycles(3 + 7 * c);
      idle_req = 1; div_present = 1; div_code = 2'(c); step();
      idle_req = 0; div_present = 0;
      dma_req = 3'(c + 1);
      cycles(40 + 25 * c);
      cur_req = "R10";
      idle_req = 1; div_present = 1; div_code = 2'(3 - c); step();
      idle_req = 0; div_present = 0;
      cur_req = "R6";
      irq_req = 4'b0010; irq_mask = 4'b0010; step();
      irq_req = 0;
      wait_resume(300, lat);
      check("R6", resume, 1, "divided wake reached");
      check("R6", (lat + 1) <= (16 << c), 1, "wake latency within n");
      dma_req = 0;
      cur_req = "R7";
      step();
    end

    cur_req = "R4";
    irq_mask = 4'b1000;
    idle_req = 1; div_present = 1; div_code = 2'b11; step();
    idle_req = 0; div_present = 0;
    irq_req = 4'b0111; cycles(300);
    check("R4", resume, 0, "masked lines in divided idle");
    irq_mask = 4'b0100; cur_req = "R6";
    wait_resume(300, lat);
    check("R6", resume, 1, "unmask then divided wake");
    irq_req = 0; step();

    cur_req = "R9";
    irq_req = 4'b0001; irq_mask = 4'b0001;
    idle_req = 1; div_present = 0; step();
    idle_req = 0; step();
    check("R9", resume, 1, "plain idle with pending irq");
    step();
    idle_req = 1; div_present = 1; div_code = 2'b01; step();
    idle_req = 0; div_present = 0;
    wait_resume(100, lat);
    check("R9", resume, 1, "divided idle with pending irq");
    irq_req = 0; cycles(4);

    cur_req = "R1";
    rst = 1; cycles(2);
    check("R1", {core_ce, sclk_ce, clkout_ce, timer_ce}, 15, "enables in reset");
    rst = 0; cycles(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule